// File: doc/BRIEF.md
# Block DMA Engine

A single-channel copy engine that moves a programmed number of bytes between host memory and a 4 KiB buffer inside the device. Software loads a source address, a destination address and a byte count, then writes the command word with the start bit set. The direction bit in that word says which side is the host and which is the buffer. The buffer is reached through a fixed device-side window at 0x40000, and host addresses must fit inside a configurable address width.

The start bit also acts as the busy flag. Software polls it and treats its return to zero as completion. A request that would run off the end of the buffer, or reach past the host address range, is refused at the moment it is started. The engine then stays idle and raises an error bit instead. Data moves one byte at a time through a small sequencer, so every count from 1 to 4096 is copied exactly. When asked to, the engine signals completion with a one-cycle interrupt request that carries cause 0x100.

Top module: `blkdma_engine`

## Requirements
- R1: After reset, every register reads 0, the engine is idle, and neither `hm_req` nor `irq_req` is asserted.
- R2: Offsets 0x80 (source), 0x88 (destination) and 0x90 (count) are 32-bit read/write registers. `reg_rdata` follows `reg_addr` combinationally. Any unmapped offset reads 0.
- R3: The command word sits at offset 0x98 and uses these bits: bit 0 is start/busy, bit 1 is direction, bit 2 is interrupt enable and bit 3 is the error flag (read-only). Writing bit 0 = 1 while idle launches a valid transfer. Bit 0 then reads 1 until the last byte has been written.
- R4: With direction 0, the engine copies exactly `count` bytes from host address `source` to buffer offset `destination - 0x40000`. It issues exactly `count` host reads and no host writes.
- R5: With direction 1, the engine copies exactly `count` bytes from buffer offset `source - 0x40000` to host address `destination`. It issues exactly `count` host writes, and the host bytes next to the range are left unchanged.
- R6: Each host access uses a word-aligned `hm_addr` and a one-hot `hm_be` that selects byte lane `addr[1:0]`. A read takes its byte from that lane. `hm_req`, `hm_we`, `hm_addr` and `hm_be` stay steady until `hm_ack`.
- R7: Some start requests are rejected. A request is rejected if the count is 0 or above 4096, if its buffer-side address is below 0x40000, or if offset plus count exceeds 4096. A rejected request leaves bit 0 at 0, sets bit 3 and makes no host access. The next accepted start clears bit 3.
- R8: While busy, writes to offsets 0x80 through 0x98 are ignored. A write that arrives in the first idle cycle takes effect.
- R9: If bit 2 was set, `irq_req` pulses for exactly one cycle with `irq_cause` = 0x100. The pulse falls in the first cycle in which bit 0 reads 0. If bit 2 was clear, no pulse occurs.
- R10: The host range `host_addr + count - 1` must not exceed 2^HOST_AW - 1 (default HOST_AW = 28). A request that does exceed it is rejected as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hm_req | output | 1 | Host memory request, held until acknowledged |
| hm_we | output | 1 | Host request is a write |
| hm_addr | output | HOST_AW | Word-aligned host byte address |
| hm_be | output | 4 | One-hot byte lane enable |
| hm_wdata | output | 32 | Host write data (byte replicated on all lanes) |
| hm_ack | input | 1 | Host memory acknowledge |
| hm_rdata | input | 32 | Host read data, valid with `hm_ack` |
| irq_req | output | 1 | One-cycle completion interrupt request |
| irq_cause | output | 32 | Interrupt cause, 0x100 during `irq_req` |

## Verification
Two events can meet on one clock edge: the end of a transfer, and a software write to a register that the transfer locks. To provoke this, the bench starts a transfer with interrupt enabled and then writes a fresh source value on every cycle. It stops right after the write that it drives in the cycle where `irq_req` is first seen high. The source register must then hold exactly that last value, so every earlier write landed on a busy edge and was dropped. Completion of copies is judged by near-exhaustive round trips over counts, byte-lane alignments and buffer offsets, with the expected bytes computed from an arithmetic host-memory pattern.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam logic [7:0]  OFF_SRC = 8'h80;
    localparam logic [7:0]  OFF_DST = 8'h88;
    localparam logic [7:0]  OFF_CNT = 8'h90;
    localparam logic [7:0]  OFF_CMD = 8'h98;
    localparam logic [31:0] IRQ_CAUSE_DMA = 32'h0000_0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } dma_state_e;

    typedef struct packed {
        logic irq_en;
        logic to_host;
    } dma_mode_t;

    // Range check applied at the moment a start is requested.
    function automatic logic xfer_ok(
        input logic [31:0] src,
        input logic [31:0] dst,
        input logic [31:0] cnt,
        input logic        to_host,
        input logic [31:0] win_base,
        input int unsigned buf_bytes,
        input int unsigned host_aw
    );
        logic [33:0] win, host, c, lim, hmax, base;
        win  = {2'b00, (to_host ? src : dst)};
        host = {2'b00, (to_host ? dst : src)};
        c    = {2'b00, cnt};
        base = {2'b00, win_base};
        lim  = 34'(buf_bytes);
        hmax = (34'd1 << host_aw) - 34'd1;
        return (c != 34'd0) && (c <= lim) && (win >= base) &&
               ((win - base + c) <= lim) && ((host + c - 34'd1) <= hmax);
    endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int unsigned HOST_AW   = 28,
    parameter int unsigned BUF_BYTES = 4096,
    parameter logic [31:0] WIN_BASE  = 32'h0004_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wen,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy,
    output logic [31:0] src_q,
    output logic [31:0] dst_q,
    output logic [31:0] cnt_q,
    output dma_mode_t   mode_q,
    output logic        go
);

    logic err_q;
    logic wr_open;
    logic cmd_wr;
    logic start_ok;

    assign wr_open  = reg_wen && !busy;
    assign cmd_wr   = wr_open && (reg_addr == OFF_CMD);
    assign start_ok = xfer_ok(src_q, dst_q, cnt_q, reg_wdata[1],
                              WIN_BASE, BUF_BYTES, HOST_AW);
    assign go       = cmd_wr && reg_wdata[0] && start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
        end else if (wr_open) begin
            case (reg_addr)
                OFF_SRC: src_q <= reg_wdata;
                OFF_DST: dst_q <= reg_wdata;
                OFF_CNT: cnt_q <= reg_wdata;
                OFF_CMD: begin
                    mode_q.irq_en  <= reg_wdata[2];
                    mode_q.to_host <= reg_wdata[1];
                    if (reg_wdata[0]) err_q <= !start_ok;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_SRC: reg_rdata = src_q;
            OFF_DST: reg_rdata = dst_q;
            OFF_CNT: reg_rdata = cnt_q;
            OFF_CMD: reg_rdata = {28'd0, err_q, mode_q.irq_en, mode_q.to_host, busy};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/blkdma_buf.sv
module blkdma_buf #(
    parameter int unsigned BUF_BYTES = 4096,
    localparam int unsigned AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
    import blkdma_pkg::*;
#(
    parameter int unsigned HOST_AW   = 28,
    parameter int unsigned BUF_BYTES = 4096,
    parameter logic [31:0] WIN_BASE  = 32'h0004_0000,
    localparam int unsigned BUF_AW   = $clog2(BUF_BYTES),
    localparam int unsigned IDX_W    = BUF_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  dma_mode_t          mode,
    input  logic [31:0]        src,
    input  logic [31:0]        dst,
    input  logic [31:0]        cnt,
    output logic               busy,
    output logic               irq_req,
    output logic               hm_req,
    output logic               hm_we,
    output logic [HOST_AW-1:0] hm_addr,
    output logic [3:0]         hm_be,
    output logic [31:0]        hm_wdata,
    input  logic               hm_ack,
    input  logic [31:0]        hm_rdata,
    output logic               buf_re,
    output logic               buf_we,
    output logic [BUF_AW-1:0]  buf_addr,
    output logic [7:0]         buf_wdata,
    input  logic [7:0]         buf_rdata
);

    dma_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [7:0]       byte_q;
    logic             irq_q;

    logic [31:0] host_base, win_off, host_a, buf_a;
    logic [31:0] lane_shift;
    logic        last;
    logic        unused_host_hi;

    assign host_base  = mode.to_host ? dst : src;
    assign win_off    = (mode.to_host ? src : dst) - WIN_BASE;
    assign host_a     = host_base + 32'(idx);
    assign buf_a      = win_off + 32'(idx);
    assign last       = (32'(idx) == (cnt - 32'd1));
    assign lane_shift = hm_rdata >> {host_a[1:0], 3'b000};

    assign busy      = (state != ST_IDLE);
    assign irq_req   = irq_q;
    assign hm_req    = ((state == ST_REQ) && !mode.to_host) ||
                       ((state == ST_WRITE) && mode.to_host);
    assign hm_we     = (state == ST_WRITE);
    assign hm_addr   = {host_a[HOST_AW-1:2], 2'b00};
    assign hm_be     = 4'b0001 << host_a[1:0];
    assign hm_wdata  = {4{byte_q}};
    assign buf_re    = (state == ST_REQ) && mode.to_host;
    assign buf_we    = (state == ST_WRITE) && !mode.to_host;
    assign buf_addr  = buf_a[BUF_AW-1:0];
    assign buf_wdata = byte_q;

    assign unused_host_hi = ^{host_a, buf_a, lane_shift[31:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            byte_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= (state == ST_DONE) && mode.irq_en;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        idx   <= '0;
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mode.to_host) begin
                        state <= ST_WAIT;
                    end else if (hm_ack) begin
                        byte_q <= lane_shift[7:0];
                        state  <= ST_WRITE;
                    end
                end
                ST_WAIT: begin
                    byte_q <= buf_rdata;
                    state  <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (!mode.to_host || hm_ack) begin
                        if (last) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_REQ;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int unsigned HOST_AW   = 28,
    parameter int unsigned BUF_BYTES = 4096,
    parameter logic [31:0] WIN_BASE  = 32'h0004_0000,
    localparam int unsigned BUF_AW   = $clog2(BUF_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wen,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               hm_req,
    output logic               hm_we,
    output logic [HOST_AW-1:0] hm_addr,
    output logic [3:0]         hm_be,
    output logic [31:0]        hm_wdata,
    input  logic               hm_ack,
    input  logic [31:0]        hm_rdata,
    output logic               irq_req,
    output logic [31:0]        irq_cause
);

    logic [31:0]       src_q, dst_q, cnt_q;
    dma_mode_t         mode_q;
    logic              go, busy;
    logic              buf_re, buf_we;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]        buf_wdata, buf_rdata;

    blkdma_regs #(.HOST_AW(HOST_AW), .BUF_BYTES(BUF_BYTES), .WIN_BASE(WIN_BASE)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .mode_q(mode_q), .go(go)
    );

    blkdma_ctrl #(.HOST_AW(HOST_AW), .BUF_BYTES(BUF_BYTES), .WIN_BASE(WIN_BASE)) u_ctrl (
        .clk(clk), .rst(rst), .go(go), .mode(mode_q),
        .src(src_q), .dst(dst_q), .cnt(cnt_q),
        .busy(busy), .irq_req(irq_req),
        .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_be(hm_be),
        .hm_wdata(hm_wdata), .hm_ack(hm_ack), .hm_rdata(hm_rdata),
        .buf_re(buf_re), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    blkdma_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst(rst),
        .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
        .re(buf_re), .raddr(buf_addr), .rdata(buf_rdata)
    );

    assign irq_cause = irq_req ? IRQ_CAUSE_DMA : 32'd0;

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
    parameter int unsigned HOST_AW = 28
) (
    input logic               clk,
    input logic               rst,
    input logic               hm_req,
    input logic               hm_ack,
    input logic               hm_we,
    input logic [HOST_AW-1:0] hm_addr,
    input logic [3:0]         hm_be,
    input logic               busy,
    input logic               irq_req,
    input logic               reg_wen,
    input logic [7:0]         reg_addr,
    input logic [31:0]        src_q
);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hm_req && !hm_ack |=> hm_req && $stable(hm_addr) && $stable(hm_we) && $stable(hm_be));

    // R6
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        hm_req |-> $countones(hm_be) == 1);

    // R3
    req_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        hm_req |-> busy);

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |=> !irq_req);

    // R9
    irq_at_finish_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !busy && $past(busy));

    // R8
    src_locked_chk: assert property (@(posedge clk) disable iff (rst)
        busy && reg_wen && reg_addr == 8'h80 |=> $stable(src_q));

endmodule

bind blkdma_engine blkdma_chk #(.HOST_AW(HOST_AW)) u_chk (
    .clk(clk), .rst(rst),
    .hm_req(hm_req), .hm_ack(hm_ack), .hm_we(hm_we), .hm_addr(hm_addr), .hm_be(hm_be),
    .busy(busy), .irq_req(irq_req),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .src_q(src_q)
);

// File: tb/blkdma_engine_bench.sv
module blkdma_engine_bench;

    localparam int HAW = 28;
    localparam logic [31:0] WIN = 32'h0004_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wen = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          hm_req, hm_we;
    logic [HAW-1:0] hm_addr;
    logic [3:0]    hm_be;
    logic [31:0]   hm_wdata;
    logic          hm_ack = 1'b0;
    logic [31:0]   hm_rdata = 32'd0;
    logic          irq_req;
    logic [31:0]   irq_cause;

    blkdma_engine u_blkdma_engine (
        .clk(clk), .rst(rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_be(hm_be),
        .hm_wdata(hm_wdata), .hm_ack(hm_ack), .hm_rdata(hm_rdata),
        .irq_req(irq_req), .irq_cause(irq_cause)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    int rd_acks = 0, wr_acks = 0, bad_port = 0;
    int irq_cnt = 0, irq_bad = 0;
    int lat = 0, wcnt = 0;
    logic [7:0] hmem [8192];

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    task automatic host_init();
        for (int i = 0; i < 8192; i++) hmem[i] = pat(i);
    endtask

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // host memory model with rotating latency
    always @(negedge clk) begin
        if (!rst && hm_req) begin
            if (hm_addr[1:0] != 2'b00 || $countones(hm_be) != 1) bad_port++;
            if (wcnt >= lat) begin
                hm_ack = 1'b1;
                if (hm_we) begin
                    for (int j = 0; j < 4; j++)
                        if (hm_be[j]) hmem[(int'(hm_addr) + j) & 8191] = hm_wdata[8*j +: 8];
                    wr_acks++;
                end else begin
                    for (int j = 0; j < 4; j++)
                        hm_rdata[8*j +: 8] = hmem[(int'(hm_addr) + j) & 8191];
                    rd_acks++;
                end
                wcnt = 0;
                lat  = (lat + 1) % 3;
            end else begin
                hm_ack = 1'b0;
                wcnt++;
            end
        end else begin
            hm_ack = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst && irq_req) begin
            irq_cnt++;
            if (irq_cause != 32'h100) irq_bad++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] d;
        int n;
        n = 0;
        do begin
            rd(8'h98, d);
            n++;
        end while (d[0] && n < 40000);
        if (d[0]) chk(1'b0, {tag, " completion"}, 1, 0);
    endtask

    // host S -> buffer O (N bytes), then buffer O -> host D
    task automatic roundtrip(input int s, input int o, input int n, input int dd);
        int r0, w0, bad;
        host_init();
        r0 = rd_acks; w0 = wr_acks;
        wr(8'h80, 32'(s)); wr(8'h88, WIN + 32'(o)); wr(8'h90, 32'(n)); wr(8'h98, 32'h1);
        wait_idle("R4");
        // R4: exact number of host reads, no host writes
        chk(rd_acks - r0 == n && wr_acks == w0, "R4 host read count", rd_acks - r0, n);
        r0 = rd_acks; w0 = wr_acks;
        wr(8'h80, WIN + 32'(o)); wr(8'h88, 32'(dd)); wr(8'h98, 32'h3);
        wait_idle("R5");
        // R5: exact number of host writes, no host reads
        chk(wr_acks - w0 == n && rd_acks == r0, "R5 host write count", wr_acks - w0, n);
        bad = 0;
        for (int a = dd - 4; a < dd + n + 4; a++) begin
            logic [7:0] e;
            e = (a >= dd && a < dd + n) ? pat(s + a - dd) : pat(a & 8191);
            if (hmem[a & 8191] != e) bad++;
        end
        // R4 R5: data moved exactly, neighbours untouched
        chk(bad == 0, "R4/R5 roundtrip data", bad, 0);
    endtask

    task automatic reject(input int s, input int dd, input int n, input logic [31:0] cmd, input string tag);
        logic [31:0] d;
        int a0;
        a0 = rd_acks + wr_acks;
        wr(8'h80, 32'(s)); wr(8'h88, 32'(dd)); wr(8'h90, 32'(n)); wr(8'h98, cmd);
        rd(8'h98, d);
        repeat (6) @(negedge clk);
        chk(d[0] == 1'b0 && d[3] == 1'b1 && (rd_acks + wr_acks) == a0, tag, d, 32'h8);
    endtask

    initial begin
        logic [31:0] d;
        int got, i0;
        host_init();
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h80, d); chk(d == 0, "R1 src after reset", d, 0);
        rd(8'h88, d); chk(d == 0, "R1 dst after reset", d, 0);
        rd(8'h90, d); chk(d == 0, "R1 cnt after reset", d, 0);
        rd(8'h98, d); chk(d == 0, "R1 cmd after reset", d, 0);
        chk(!hm_req && !irq_req, "R1 outputs idle", {hm_req, irq_req}, 0);

        // R2 readback and unmapped offset
        wr(8'h80, 32'h1234_5678); wr(8'h88, 32'h9ABC_DEF0); wr(8'h90, 32'h0000_0FFF);
        rd(8'h80, d); chk(d == 32'h1234_5678, "R2 src readback", d, 32'h1234_5678);
        rd(8'h88, d); chk(d == 32'h9ABC_DEF0, "R2 dst readback", d, 32'h9ABC_DEF0);
        rd(8'h90, d); chk(d == 32'h0000_0FFF, "R2 cnt readback", d, 32'hFFF);
        rd(8'h84, d); chk(d == 0, "R2 unmapped offset", d, 0);

        // R3 busy visible right after start, fields read back after finish
        wr(8'h80, 32'h40); wr(8'h88, WIN); wr(8'h90, 32'd8); wr(8'h98, 32'h1);
        rd(8'h98, d); chk(d[0] == 1'b1, "R3 busy after start", d[0], 1);
        wait_idle("R3");
        wr(8'h80, WIN); wr(8'h88, 32'h800); wr(8'h98, 32'h3);
        wait_idle("R3");
        rd(8'h98, d); chk(d == 32'h2, "R3 cmd after dir1 transfer", d, 2);

        // R4 R5 R6 near-exhaustive sweep: counts x lane alignments
        for (int n = 1; n <= 6; n++)
            for (int al = 0; al < 4; al++)
                roundtrip(32'h100 + al + n * 16, n * 7 + al, n, 32'h1000 + (3 - al) + n * 32);
        roundtrip(3, 4000, 96, 32'h1201);
        roundtrip(0, 0, 4096, 32'h1000);
        // R6 port discipline over all transfers
        chk(bad_port == 0, "R6 aligned address, one-hot lane", bad_port, 0);

        // R7 rejects
        reject(32'h10, WIN, 0, 32'h1, "R7 count zero");
        reject(32'h10, WIN, 4097, 32'h1, "R7 count above 4096");
        reject(32'h10, WIN - 1, 4, 32'h1, "R7 window below base");
        reject(32'h10, WIN + 4095, 2, 32'h1, "R7 offset plus count past end");
        reject(WIN + 4090, 32'h10, 7, 32'h3, "R7 dir1 source past end");
        // R10 host range past mask
        reject(32'h0FFF_FFFF, WIN, 2, 32'h1, "R10 host end beyond 28-bit range");
        // R10 boundary accepted, R7 error cleared
        wr(8'h80, 32'h0FFF_FFFE); wr(8'h88, WIN); wr(8'h90, 32'd2); wr(8'h98, 32'h1);
        rd(8'h98, d);
        chk(d[0] == 1'b1 && d[3] == 1'b0, "R10 range end at limit accepted, R7 error cleared", d, 1);
        wait_idle("R10");

        // R8 writes while busy ignored, R9 no irq when disabled
        i0 = irq_cnt;
        wr(8'h80, 32'h200); wr(8'h88, WIN + 32'd100); wr(8'h90, 32'd40); wr(8'h98, 32'h1);
        wr(8'h80, 32'hDEAD); wr(8'h90, 32'd1); wr(8'h98, 32'h6);
        wait_idle("R8");
        rd(8'h80, d); chk(d == 32'h200, "R8 src write while busy", d, 32'h200);
        rd(8'h90, d); chk(d == 32'd40, "R8 cnt write while busy", d, 40);
        rd(8'h98, d); chk(d == 32'h0, "R8 cmd write while busy", d, 0);
        chk(irq_cnt == i0, "R9 no pulse when disabled", irq_cnt - i0, 0);

        // R8 R9 collision: write src every cycle until the irq cycle
        i0 = irq_cnt;
        wr(8'h80, 32'h300); wr(8'h88, WIN); wr(8'h90, 32'd12); wr(8'h98, 32'h5);
        got = -1;
        for (int k = 1; k < 20000; k++) begin
            @(negedge clk);
            reg_wen = 1'b1; reg_addr = 8'h80; reg_wdata = 32'(k);
            #1;
            if (irq_req) begin got = k; break; end
        end
        @(posedge clk);
        #1 reg_wen = 1'b0;
        rd(8'h98, d); chk(d[0] == 1'b0, "R9 busy clear with pulse", d[0], 0);
        rd(8'h80, d); chk(d == 32'(got), "R8 write at first idle cycle kept", d, got);
        repeat (4) @(negedge clk);
        chk(irq_cnt - i0 == 1 && irq_bad == 0, "R9 one pulse with cause 0x100", irq_cnt - i0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired R3 actual=hung expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule